// File: doc/BRIEF.md
# CAN Controller Global Control Register

This block holds the byte-wide global control register of a CAN controller and turns its bits into the sequencing signals that the rest of the controller needs. The CPU writes and reads the register through a simple byte port. The register value is always visible on the read bus. Some bits are plain settings. Others are commands: the general-reset and overload-request bits clear themselves, and the abort bit stays set until software clears it.

The block runs the enable/standby sequence for the protocol core. When the enable bit is set, the core clock gate opens first and the core enable follows after a fixed startup delay. When the enable bit is cleared, the block waits until the frame in progress has finished, then drops the core enable and closes the clock gate. From then on the transmit line is held recessive. A software reset is merged with the hardware reset, and the controller always ends up disabled after either one.

In time-triggered mode the block produces a one-cycle timer-capture strobe. A select bit chooses whether the strobe follows start of frame or the last bit of end of frame. While the abort bit is set, the block sends a channel-disable strobe to every mailbox.

Top module: `can_gctl`

## Requirements
- R1: After reset the register reads 0x00. In that state `core_en`, `clk_gate_en`, `chan_dis`, `ovl_req` and `ts_capture` are 0, and `tx_force_rec` is 1.
- R2: Register bit positions are: 7 abort, 6 overload request, 5 time-trigger mode, 4 capture select, 3 listen, 2 test, 1 enable, 0 general reset. A written value reads back on `rd_data` on the cycle after the write. Bit 3 drives `listen_mode`. Bit 2 is stored but has no effect on any other output.
- R3: A write with bit 0 set makes the register read 0x01 for one cycle and 0x00 after that. All other bits are cleared. `ctrl_reset` is high for exactly that one cycle, and `core_en` and `clk_gate_en` are 0 afterwards. `ctrl_reset` is also high while `rst` is applied.
- R4: `clk_gate_en` rises one cycle after the enable bit reads 1. `core_en` rises START_DLY cycles after the enable bit reads 1 (2 by default).
- R5: After the enable bit is cleared, `core_en` and `clk_gate_en` stay high while `frame_busy` is 1. They fall on the first clock edge at which `frame_busy` is sampled 0. If the enable bit is cleared while `frame_busy` is already 0, they fall on the next edge.
- R6: `tx_force_rec` is 1 exactly when `core_en` is 0.
- R7: The abort bit does not clear itself. While it reads 1, every bit of `chan_dis` is 1, starting one cycle after it is set. `chan_dis` stays 0 in every other case, including during the standby transition.
- R8: `ovl_req` follows bit 6. The bit clears on the edge after `ovl_start` is seen while it is set. A CPU write on that same edge takes priority over the clear.
- R9: With bit 5 set, `ts_capture` pulses one cycle after `sof_seen` when bit 4 is 0, and one cycle after `eof_last` when bit 4 is 1. The other event gives no pulse.
- R10: With bit 5 clear, `ts_capture` stays 0 for any `sof_seen` or `eof_last` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register value |
| frame_busy | input | 1 | Protocol engine has a frame in progress |
| ovl_start | input | 1 | Overload frame transmission begins |
| sof_seen | input | 1 | Start of frame pulse |
| eof_last | input | 1 | Last bit of end of frame pulse |
| core_en | output | 1 | Protocol core enable |
| clk_gate_en | output | 1 | Core clock gate enable |
| tx_force_rec | output | 1 | Hold transmit output recessive |
| listen_mode | output | 1 | Passive listening mode select |
| ovl_req | output | 1 | Overload frame request to the engine |
| ts_capture | output | 1 | Timer capture strobe |
| chan_dis | output | NUM_MBOX | Per-mailbox channel-disable strobe |
| ctrl_reset | output | 1 | Merged hardware/software controller reset |

## Verification
Some rules are checked by assertions on every cycle:
- the core enable never runs without the clock gate;
- the core enable rises only after the enable bit was set, and falls only when no frame is busy or a reset was applied;
- the overload bit clears after its start pulse unless a write collides with it;
- the general-reset bit never lasts beyond one cycle;
- capture and channel-disable strobes only follow their enabling bits.

Other behaviour can only be shown by the bench's scenarios:
- the exact startup delay;
- how long standby is held off while a frame is busy;
- which frame event the capture select picks;
- that the test and listen bits leave the sequencing alone;
- that a write wins over a simultaneous hardware clear.

// File: rtl/can_gctl_pkg.sv
package can_gctl_pkg;
  localparam int CTRL_W   = 8;
  localparam int B_ABORT  = 7;
  localparam int B_OVL    = 6;
  localparam int B_TTM    = 5;
  localparam int B_SYNC   = 4;
  localparam int B_LISTEN = 3;
  localparam int B_TEST   = 2;
  localparam int B_EN     = 1;
  localparam int B_GRES   = 0;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_WAKE  = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } run_state_t;
endpackage

// File: rtl/can_gctl_regs.sv
module can_gctl_regs
  import can_gctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              ovl_start,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              soft_rst_q
);
  localparam logic [CTRL_W-1:0] GRES_ONLY = CTRL_W'(1) << B_GRES;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      soft_rst_q <= 1'b1;
    end else begin
      soft_rst_q <= wr_en & wr_data[B_GRES];
      if (wr_en) begin
        // a soft reset write clears every other bit as well
        if (wr_data[B_GRES]) ctrl_q <= GRES_ONLY;
        else                 ctrl_q <= wr_data;
      end else begin
        if (ovl_start) ctrl_q[B_OVL] <= 1'b0;
        ctrl_q[B_GRES] <= 1'b0;
      end
    end
  end

  assert_ovl_autoclear_R8: assert property (@(posedge clk) disable iff (rst)
    (ovl_start && ctrl_q[B_OVL] && !wr_en) |=> !ctrl_q[B_OVL]);

  assert_gres_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[B_GRES] && !wr_en) |=> (ctrl_q == '0));
endmodule

// File: rtl/can_gctl_seq.sv
module can_gctl_seq
  import can_gctl_pkg::*;
#(
  parameter int START_DLY = 2
) (
  input  logic clk,
  input  logic rst_all,
  input  logic en_bit,
  input  logic frame_busy,
  output logic core_en,
  output logic gate_en
);
  localparam int CW = (START_DLY > 2) ? $clog2(START_DLY) : 1;
  localparam logic [CW-1:0] LAST = CW'(START_DLY - 1);

  run_state_t state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst_all) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      core_en <= 1'b0;
      gate_en <= 1'b0;
    end else begin
      unique case (state_q)
        ST_OFF: if (en_bit) begin
          state_q <= ST_WAKE;
          cnt_q   <= CW'(1);
          gate_en <= 1'b1;
        end
        ST_WAKE: begin
          if (!en_bit) begin
            state_q <= ST_OFF;
            gate_en <= 1'b0;
          end else if (cnt_q == LAST) begin
            state_q <= ST_RUN;
            core_en <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_RUN, ST_DRAIN: begin
          if (en_bit) begin
            state_q <= ST_RUN;
          end else if (!frame_busy) begin
            state_q <= ST_OFF;
            core_en <= 1'b0;
            gate_en <= 1'b0;
          end else begin
            state_q <= ST_DRAIN;
          end
        end
        default: state_q <= ST_OFF;
      endcase
    end
  end

  assert_core_needs_gate_R4: assert property (@(posedge clk) disable iff (rst_all)
    core_en |-> gate_en);

  assert_core_rise_after_enable_R4: assert property (@(posedge clk) disable iff (rst_all)
    $rose(core_en) |-> $past(en_bit));

  assert_standby_waits_frame_R5: assert property (@(posedge clk) disable iff (rst_all)
    ($fell(core_en) && !$past(rst_all)) |-> !$past(frame_busy));
endmodule

// File: rtl/can_gctl_tstamp.sv
module can_gctl_tstamp (
  input  logic clk,
  input  logic rst,
  input  logic ttm_on,
  input  logic at_eof,
  input  logic sof_seen,
  input  logic eof_last,
  output logic cap_q
);
  always_ff @(posedge clk) begin
    if (rst) cap_q <= 1'b0;
    else     cap_q <= ttm_on & (at_eof ? eof_last : sof_seen);
  end

  assert_capture_needs_ttm_R10: assert property (@(posedge clk) disable iff (rst)
    cap_q |-> $past(ttm_on));
endmodule

// File: rtl/can_gctl.sv
module can_gctl
  import can_gctl_pkg::*;
#(
  parameter int NUM_MBOX  = 8,
  parameter int START_DLY = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [7:0]          wr_data,
  output logic [7:0]          rd_data,
  input  logic                frame_busy,
  input  logic                ovl_start,
  input  logic                sof_seen,
  input  logic                eof_last,
  output logic                core_en,
  output logic                clk_gate_en,
  output logic                tx_force_rec,
  output logic                listen_mode,
  output logic                ovl_req,
  output logic                ts_capture,
  output logic [NUM_MBOX-1:0] chan_dis,
  output logic                ctrl_reset
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              soft_rst_q;
  logic              rst_all;

  can_gctl_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .ovl_start  (ovl_start),
    .ctrl_q     (ctrl_q),
    .soft_rst_q (soft_rst_q)
  );

  assign rst_all = rst | ctrl_q[B_GRES];

  can_gctl_seq #(.START_DLY(START_DLY)) u_seq (
    .clk        (clk),
    .rst_all    (rst_all),
    .en_bit     (ctrl_q[B_EN]),
    .frame_busy (frame_busy),
    .core_en    (core_en),
    .gate_en    (clk_gate_en)
  );

  can_gctl_tstamp u_ts (
    .clk      (clk),
    .rst      (rst_all),
    .ttm_on   (ctrl_q[B_TTM]),
    .at_eof   (ctrl_q[B_SYNC]),
    .sof_seen (sof_seen),
    .eof_last (eof_last),
    .cap_q    (ts_capture)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_MBOX; gi++) begin : g_mbox
      always_ff @(posedge clk) begin
        if (rst) chan_dis[gi] <= 1'b0;
        else     chan_dis[gi] <= ctrl_q[B_ABORT];
      end

      assert_chan_dis_from_abort_R7: assert property (@(posedge clk) disable iff (rst)
        chan_dis[gi] |-> $past(ctrl_q[B_ABORT]));
    end
  endgenerate

  assign rd_data      = ctrl_q;
  assign tx_force_rec = ~core_en;
  assign listen_mode  = ctrl_q[B_LISTEN];
  assign ovl_req      = ctrl_q[B_OVL];
  assign ctrl_reset   = soft_rst_q;

  assert_tx_recessive_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_force_rec != core_en));
endmodule

// File: tb/tb_can_gctl.sv
`timescale 1ns/1ps
module tb_can_gctl;
  localparam int NMB = 8;

  logic clk = 1'b0;
  logic rst, wr_en, frame_busy, ovl_start, sof_seen, eof_last;
  logic [7:0] wr_data, rd_data;
  logic core_en, clk_gate_en, tx_force_rec, listen_mode, ovl_req, ts_capture, ctrl_reset;
  logic [NMB-1:0] chan_dis;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  can_gctl #(.NUM_MBOX(NMB), .START_DLY(2)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .frame_busy(frame_busy), .ovl_start(ovl_start), .sof_seen(sof_seen),
    .eof_last(eof_last), .core_en(core_en), .clk_gate_en(clk_gate_en),
    .tx_force_rec(tx_force_rec), .listen_mode(listen_mode), .ovl_req(ovl_req),
    .ts_capture(ts_capture), .chan_dis(chan_dis), .ctrl_reset(ctrl_reset)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset_state;
    chk("R1", "rd_data", rd_data, 8'h00);
    chk("R1", "core_en", core_en, 1'b0);
    chk("R1", "clk_gate_en", clk_gate_en, 1'b0);
    chk("R1", "tx_force_rec", tx_force_rec, 1'b1);
    chk("R1", "chan_dis", chan_dis, '0);
    chk("R1", "ovl_req", ovl_req, 1'b0);
    chk("R1", "ts_capture", ts_capture, 1'b0);
  endtask

  task automatic t_readback;
    wr(8'h08);
    chk("R2", "listen readback", rd_data, 8'h08);
    chk("R2", "listen_mode", listen_mode, 1'b1);
    wr(8'h04);
    chk("R2", "test readback", rd_data, 8'h04);
    tick(3);
    chk("R2", "test no core_en", core_en, 1'b0);
    chk("R2", "test no gate", clk_gate_en, 1'b0);
    chk("R2", "test no listen", listen_mode, 1'b0);
    chk("R2", "test no chan_dis", chan_dis, '0);
    wr(8'h00);
  endtask

  task automatic t_startup;
    wr(8'h02);
    chk("R4", "gate after write", clk_gate_en, 1'b0);
    chk("R4", "core after write", core_en, 1'b0);
    tick(1);
    chk("R4", "gate +1", clk_gate_en, 1'b1);
    chk("R4", "core +1", core_en, 1'b0);
    chk("R6", "tx rec while waking", tx_force_rec, 1'b1);
    tick(1);
    chk("R4", "core +2", core_en, 1'b1);
    chk("R6", "tx released", tx_force_rec, 1'b0);
  endtask

  task automatic t_standby_drain;
    frame_busy = 1'b1;
    wr(8'h00);
    for (int i = 0; i < 4; i++) begin
      chk("R5", "core held while busy", core_en, 1'b1);
      chk("R7", "no chan_dis in standby", chan_dis, '0);
      tick(1);
    end
    frame_busy = 1'b0;
    tick(1);
    chk("R5", "core off after busy low", core_en, 1'b0);
    chk("R5", "gate off after busy low", clk_gate_en, 1'b0);
    chk("R6", "tx recessive in standby", tx_force_rec, 1'b1);
  endtask

  task automatic t_standby_idle;
    wr(8'h02);
    tick(3);
    chk("R4", "core running", core_en, 1'b1);
    wr(8'h00);
    chk("R5", "core still on at write edge", core_en, 1'b1);
    tick(1);
    chk("R5", "core off next edge", core_en, 1'b0);
  endtask

  task automatic t_soft_reset;
    wr(8'h02);
    tick(3);
    wr(8'h2A);
    chk("R2", "multi bit readback", rd_data, 8'h2A);
    wr(8'h01);
    chk("R3", "gres reads 0x01", rd_data, 8'h01);
    chk("R3", "ctrl_reset high", ctrl_reset, 1'b1);
    tick(1);
    chk("R3", "gres self cleared", rd_data, 8'h00);
    chk("R3", "ctrl_reset low", ctrl_reset, 1'b0);
    chk("R3", "core disabled", core_en, 1'b0);
    chk("R3", "gate disabled", clk_gate_en, 1'b0);
  endtask

  task automatic t_abort;
    wr(8'h80);
    tick(1);
    chk("R7", "chan_dis all set", chan_dis, {NMB{1'b1}});
    tick(5);
    chk("R7", "abort sticky", rd_data, 8'h80);
    chk("R7", "chan_dis held", chan_dis, {NMB{1'b1}});
    wr(8'h00);
    tick(1);
    chk("R7", "chan_dis released", chan_dis, '0);
  endtask

  task automatic t_overload;
    wr(8'h40);
    chk("R8", "ovl_req set", ovl_req, 1'b1);
    tick(2);
    chk("R8", "ovl_req held", ovl_req, 1'b1);
    ovl_start = 1'b1;
    tick(1);
    ovl_start = 1'b0;
    chk("R8", "ovl cleared by hw", ovl_req, 1'b0);
    ovl_start = 1'b1;
    wr(8'h40);
    ovl_start = 1'b0;
    chk("R8", "write wins over clear", ovl_req, 1'b1);
    wr(8'h00);
  endtask

  task automatic pulse_ev(input bit eof, output logic seen);
    if (eof) eof_last = 1'b1; else sof_seen = 1'b1;
    tick(1);
    eof_last = 1'b0; sof_seen = 1'b0;
    seen = ts_capture;
    tick(1);
  endtask

  task automatic t_capture;
    logic s;
    wr(8'h20);
    pulse_ev(1'b0, s); chk("R9", "sof capture", s, 1'b1);
    pulse_ev(1'b1, s); chk("R9", "eof ignored in sof mode", s, 1'b0);
    wr(8'h30);
    pulse_ev(1'b1, s); chk("R9", "eof capture", s, 1'b1);
    pulse_ev(1'b0, s); chk("R9", "sof ignored in eof mode", s, 1'b0);
    wr(8'h10);
    pulse_ev(1'b1, s); chk("R10", "no eof capture w/o ttm", s, 1'b0);
    pulse_ev(1'b0, s); chk("R10", "no sof capture w/o ttm", s, 1'b0);
    wr(8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = 8'h00; frame_busy = 1'b0;
    ovl_start = 1'b0; sof_seen = 1'b0; eof_last = 1'b0;
    tick(3);
    chk("R3", "ctrl_reset during rst", ctrl_reset, 1'b1);
    rst = 1'b0;
    tick(1);
    t_reset_state();
    t_readback();
    t_startup();
    t_standby_drain();
    t_standby_idle();
    t_soft_reset();
    t_abort();
    t_overload();
    t_capture();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule